// File: doc/BRIEF.md
# Pairwise Dueling Fault Isolation Unit

This unit narrows down which one of a set of logic resources is faulty. It watches the outcomes of paired configuration runs. Configurations come in two equal groups, A and B. Each pairing takes one configuration from each group, and the two use disjoint resources. For every pairing the unit receives the index of each configuration, a resource-usage bitmask for each, and the comparator's agree/disagree verdict.

The unit keeps a suspect mask, which starts with every resource suspected. A disagreement intersects the mask with the union of the two configurations' resources. In the perpetual articulation mode, an agreement clears from the mask every resource that either configuration used. In the intermittent mode, an agreement carries no location information and leaves the mask unchanged. When exactly one suspect remains, the unit raises its done flag, reports the index of that resource and freezes the mask.

Each configuration also has a saturating fitness counter. An agreement raises it and a disagreement lowers it. For each group the unit reports the configuration with the best fitness, which the controller can prefer in later pairings.

Top module: `dueling_isolator`

## Requirements
- R1: After reset or a synchronous clear, the suspect mask is all ones, done is low, and every fitness counter holds its midpoint 2^(FIT_W-1). With all counters equal, both preferred outputs read 0.
- R2: A valid pairing with match=0 replaces the suspect mask with suspect AND (res_a OR res_b) at the next clock edge.
- R3: A valid pairing with match=1 and mode=0 (perpetual) replaces the suspect mask with suspect AND NOT (res_a OR res_b) at the next clock edge.
- R4: A valid pairing with match=1 and mode=1 (intermittent) leaves the suspect mask unchanged.
- R5: done is high exactly when one suspect bit is set. iso_idx is the position of the lowest set suspect bit, and 0 when the mask is empty.
- R6: While done is high, pairings do not change the suspect mask.
- R7: A valid pairing with match=1 increments the fitness of configuration cfg_a in group A and of cfg_b in group B. A counter saturates at 2^FIT_W-1.
- R8: A valid pairing with match=0 decrements both counters. A counter saturates at 0.
- R9: pref_a and pref_b give the index of the highest fitness in their group. On a tie, the lowest index wins.
- R10: clr takes priority over a pairing presented in the same cycle.
- R11: With pair_valid low, neither the suspect mask nor any fitness counter changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all tracking state |
| mode | input | 1 | 0 = perpetual articulation, 1 = intermittent articulation |
| pair_valid | input | 1 | A pairing outcome is presented this cycle |
| cfg_a | input | CFG_IW | Index of the group A configuration in the pairing |
| cfg_b | input | CFG_IW | Index of the group B configuration in the pairing |
| res_a | input | NRES | Resources used by the group A configuration |
| res_b | input | NRES | Resources used by the group B configuration |
| match | input | 1 | 1 = the two outputs agreed, 0 = discrepancy |
| suspect | output | NRES | Current suspect mask |
| done | output | 1 | Exactly one suspect remains |
| iso_idx | output | RES_IW | Index of the lowest suspect bit |
| pref_a | output | CFG_IW | Preferred group A configuration |
| pref_b | output | CFG_IW | Preferred group B configuration |

## Verification

The bench targets four boundaries:
- **Fitness saturation at both ends.** A counter that wraps instead of sticking jumps to the top or the bottom of the ranking, so the preferred index changes to the wrong configuration.
- **The tie rule.** Picking the highest index on a tie would show up right after a clear.
- **A discrepancy after isolation.** If such a pairing empties the mask, done drops and the isolated index is lost.
- **Matches in the intermittent mode.** If they exonerate resources anyway, the mask shrinks where it must hold.

The bench also checks that a clear wins over a pairing presented in the same cycle, and that inputs shown without pair_valid change no state.

// File: rtl/dfi_pkg.sv
package dfi_pkg;
  typedef enum logic {
    ART_PERPETUAL    = 1'b0,
    ART_INTERMITTENT = 1'b1
  } art_mode_e;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_AGREE    = 2'd1,
    EV_DISAGREE = 2'd2
  } duel_ev_e;
endpackage

// File: rtl/suspect_tracker.sv
module suspect_tracker
  import dfi_pkg::*;
#(
  parameter int NRES   = 16,
  parameter int RES_IW = $clog2(NRES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  duel_ev_e          ev,
  input  art_mode_e         mode,
  input  logic [NRES-1:0]   cand,
  output logic [NRES-1:0]   suspect,
  output logic              done,
  output logic [RES_IW-1:0] iso_idx
);

  function automatic logic [RES_IW:0] count_ones(input logic [NRES-1:0] v);
    logic [RES_IW:0] n;
    n = '0;
    for (int i = 0; i < NRES; i++) n = n + {{RES_IW{1'b0}}, v[i]};
    return n;
  endfunction

  function automatic logic [RES_IW-1:0] lowest_set(input logic [NRES-1:0] v);
    logic [RES_IW-1:0] k;
    k = '0;
    for (int i = NRES - 1; i >= 0; i--) begin
      if (v[i]) k = RES_IW'(i);
    end
    return k;
  endfunction

  // Named events, kept visible for the assertions below
  logic narrow_ev;
  logic exon_ev;

  assign done      = (count_ones(suspect) == (RES_IW+1)'(1));
  assign iso_idx   = lowest_set(suspect);
  assign narrow_ev = (ev == EV_DISAGREE) && !done;
  assign exon_ev   = (ev == EV_AGREE) && (mode == ART_PERPETUAL) && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         suspect <= '1;
    else if (clr)       suspect <= '1;
    else if (narrow_ev) suspect <= suspect & cand;
    else if (exon_ev)   suspect <= suspect & ~cand;
  end

  p_clear_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (&suspect));

  p_disc_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_DISAGREE && !done && !clr) |=> ((suspect & ~$past(cand)) == '0));

  p_agree_exon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_AGREE && mode == ART_PERPETUAL && !done && !clr)
      |=> ((suspect & $past(cand)) == '0));

  p_intermit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_AGREE && mode == ART_INTERMITTENT && !clr) |=> $stable(suspect));

  p_iso_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> suspect[iso_idx]);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> $stable(suspect));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE && !clr) |=> $stable(suspect));

endmodule

// File: rtl/fitness_bank.sv
module fitness_bank #(
  parameter int NCFG   = 4,
  parameter int FIT_W  = 4,
  parameter int CFG_IW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       upd,
  input  logic                       up,
  input  logic [CFG_IW-1:0]          idx,
  output logic [NCFG-1:0][FIT_W-1:0] fit
);

  localparam logic [FIT_W-1:0] FIT_MID = {1'b1, {(FIT_W-1){1'b0}}};
  localparam logic [FIT_W-1:0] FIT_MAX = {FIT_W{1'b1}};

  function automatic logic [FIT_W-1:0] sat_step(input logic [FIT_W-1:0] v,
                                                input logic inc);
    if (inc) return (v == FIT_MAX) ? v : v + 1'b1;
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) fit[i] <= FIT_MID;
    end else if (clr) begin
      for (int i = 0; i < NCFG; i++) fit[i] <= FIT_MID;
    end else if (upd) begin
      for (int i = 0; i < NCFG; i++) begin
        if (idx == CFG_IW'(i)) fit[i] <= sat_step(fit[i], up);
      end
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_chk
    logic hit;
    assign hit = upd && !clr && (idx == CFG_IW'(g));

    p_clear_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fit[g] == FIT_MID));

    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && up && fit[g] == FIT_MAX) |=> (fit[g] == FIT_MAX));

    p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && up && fit[g] != FIT_MAX) |=> (fit[g] == $past(fit[g]) + 1'b1));

    p_sat_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !up && fit[g] == '0) |=> (fit[g] == '0));

    p_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !up && fit[g] != '0) |=> (fit[g] == $past(fit[g]) - 1'b1));

    p_idle_fit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !clr) |=> $stable(fit[g]));
  end

endmodule

// File: rtl/best_picker.sv
module best_picker #(
  parameter int NCFG   = 4,
  parameter int FIT_W  = 4,
  parameter int CFG_IW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCFG-1:0][FIT_W-1:0] fit,
  output logic [CFG_IW-1:0]          best
);

  logic [FIT_W-1:0] best_val;

  always_comb begin
    best     = '0;
    best_val = fit[0];
    for (int i = 1; i < NCFG; i++) begin
      if (fit[i] > best_val) begin
        best     = CFG_IW'(i);
        best_val = fit[i];
      end
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_chk
    p_pick_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fit[g] <= fit[best]);

    p_pick_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (CFG_IW'(g) < best) |-> (fit[g] < fit[best]));
  end

endmodule

// File: rtl/dueling_isolator.sv
module dueling_isolator
  import dfi_pkg::*;
#(
  parameter int NRES   = 16,
  parameter int NCFG   = 4,
  parameter int FIT_W  = 4,
  parameter int RES_IW = $clog2(NRES),
  parameter int CFG_IW = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mode,
  input  logic              pair_valid,
  input  logic [CFG_IW-1:0] cfg_a,
  input  logic [CFG_IW-1:0] cfg_b,
  input  logic [NRES-1:0]   res_a,
  input  logic [NRES-1:0]   res_b,
  input  logic              match,
  output logic [NRES-1:0]   suspect,
  output logic              done,
  output logic [RES_IW-1:0] iso_idx,
  output logic [CFG_IW-1:0] pref_a,
  output logic [CFG_IW-1:0] pref_b
);

  duel_ev_e                   ev;
  logic [NRES-1:0]            cand;
  logic [NCFG-1:0][FIT_W-1:0] fit_a;
  logic [NCFG-1:0][FIT_W-1:0] fit_b;

  assign ev   = !pair_valid ? EV_NONE : (match ? EV_AGREE : EV_DISAGREE);
  assign cand = res_a | res_b;

  suspect_tracker #(.NRES(NRES), .RES_IW(RES_IW)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .ev      (ev),
    .mode    (art_mode_e'(mode)),
    .cand    (cand),
    .suspect (suspect),
    .done    (done),
    .iso_idx (iso_idx)
  );

  fitness_bank #(.NCFG(NCFG), .FIT_W(FIT_W), .CFG_IW(CFG_IW)) u_fit_a (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .upd   (pair_valid),
    .up    (match),
    .idx   (cfg_a),
    .fit   (fit_a)
  );

  fitness_bank #(.NCFG(NCFG), .FIT_W(FIT_W), .CFG_IW(CFG_IW)) u_fit_b (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .upd   (pair_valid),
    .up    (match),
    .idx   (cfg_b),
    .fit   (fit_b)
  );

  best_picker #(.NCFG(NCFG), .FIT_W(FIT_W), .CFG_IW(CFG_IW)) u_pick_a (
    .clk   (clk),
    .rst_n (rst_n),
    .fit   (fit_a),
    .best  (pref_a)
  );

  best_picker #(.NCFG(NCFG), .FIT_W(FIT_W), .CFG_IW(CFG_IW)) u_pick_b (
    .clk   (clk),
    .rst_n (rst_n),
    .fit   (fit_b),
    .best  (pref_b)
  );

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && pair_valid) |=> ((&suspect) && !done));

endmodule

// File: tb/dueling_isolator_test.sv
module dueling_isolator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRES = 16;
  localparam int NCFG = 4;
  localparam int FW   = 4;
  localparam int FMID = 8;
  localparam int FMAX = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        mode = 1'b0;
  logic        pair_valid = 1'b0;
  logic [1:0]  cfg_a = '0;
  logic [1:0]  cfg_b = '0;
  logic [15:0] res_a = '0;
  logic [15:0] res_b = '0;
  logic        match = 1'b0;
  logic [15:0] suspect;
  logic        done;
  logic [3:0]  iso_idx;
  logic [1:0]  pref_a;
  logic [1:0]  pref_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] m_sus;
  int m_fa[NCFG];
  int m_fb[NCFG];

  always #(CLK_PERIOD/2) clk = ~clk;

  dueling_isolator #(.NRES(NRES), .NCFG(NCFG), .FIT_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .pair_valid(pair_valid),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .res_a(res_a), .res_b(res_b), .match(match),
    .suspect(suspect), .done(done), .iso_idx(iso_idx),
    .pref_a(pref_a), .pref_b(pref_b)
  );

  function automatic int low_bit(input logic [15:0] s);
    for (int i = 0; i < 16; i++) if (s[i]) return i;
    return 0;
  endfunction

  function automatic int argmax(input int f[NCFG]);
    int b = 0;
    for (int i = 0; i < NCFG; i++) if (f[i] > f[b]) b = i;
    return b;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "suspect", int'(suspect), int'(m_sus));
    cmp(tag, "done", int'(done), ($countones(m_sus) == 1) ? 1 : 0);
    cmp(tag, "iso_idx", int'(iso_idx), low_bit(m_sus));
    cmp(tag, "pref_a", int'(pref_a), argmax(m_fa));
    cmp(tag, "pref_b", int'(pref_b), argmax(m_fb));
  endtask

  task automatic model_clear();
    m_sus = '1;
    for (int i = 0; i < NCFG; i++) begin
      m_fa[i] = FMID;
      m_fb[i] = FMID;
    end
  endtask

  // One clock with the given inputs; the model is advanced, then checked after the edge
  task automatic step(input string tag, input bit c, input bit v, input bit md,
                      input bit mt, input int ca, input int cb,
                      input logic [15:0] ra, input logic [15:0] rb);
    @(negedge clk);
    clr = c; pair_valid = v; mode = md; match = mt;
    cfg_a = 2'(ca); cfg_b = 2'(cb); res_a = ra; res_b = rb;
    @(posedge clk);
    #1;
    if (c) model_clear();
    else if (v) begin
      if ($countones(m_sus) != 1) begin
        if (!mt) m_sus = m_sus & (ra | rb);
        else if (!md) m_sus = m_sus & ~(ra | rb);
      end
      if (mt) begin
        m_fa[ca] = (m_fa[ca] < FMAX) ? m_fa[ca] + 1 : FMAX;
        m_fb[cb] = (m_fb[cb] < FMAX) ? m_fb[cb] + 1 : FMAX;
      end else begin
        m_fa[ca] = (m_fa[ca] > 0) ? m_fa[ca] - 1 : 0;
        m_fb[cb] = (m_fb[cb] > 0) ? m_fb[cb] - 1 : 0;
      end
    end
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // Ties after reset pick index 0 (R9); ceiling saturation on A2/B1 (R7)
    for (int k = 0; k < 10; k++) step("R7 R9 ceiling", 0, 1, 1, 1, 2, 1, 16'h0, 16'h0);
    // Floor saturation on A3/B3 (R8)
    for (int k = 0; k < 18; k++) step("R8 floor", 0, 1, 1, 0, 3, 3, 16'h0, 16'h0);
    step("R1 clear", 1, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    for (int k = 0; k < 9; k++) step("R8 floor A0", 0, 1, 1, 0, 0, 0, 16'h0, 16'h0);
    step("R9 tie", 1, 0, 0, 0, 0, 0, 16'h0, 16'h0);

    // Directed narrowing sequence
    step("R3 perpetual agree", 0, 1, 0, 1, 0, 1, 16'h000F, 16'h00F0);
    step("R2 discrepancy", 0, 1, 0, 0, 1, 2, 16'h0300, 16'h0C00);
    step("R4 intermittent agree", 0, 1, 1, 1, 2, 0, 16'h0100, 16'h0200);
    step("R11 idle", 0, 0, 0, 0, 3, 3, 16'h0F00, 16'h0000);
    step("R3 perpetual agree", 0, 1, 0, 1, 2, 0, 16'h0100, 16'h0200);
    step("R5 isolate", 0, 1, 0, 0, 0, 2, 16'h0400, 16'h0001);
    step("R6 frozen disc", 0, 1, 0, 0, 1, 1, 16'h0001, 16'h0002);
    step("R6 frozen agree", 0, 1, 0, 1, 1, 1, 16'h0400, 16'h0000);
    step("R10 clear wins", 1, 1, 0, 0, 3, 3, 16'h0001, 16'h0002);
    step("R5 empty", 0, 1, 0, 0, 0, 0, 16'h0000, 16'h0000);
    step("R1 clear", 1, 0, 0, 0, 0, 0, 16'h0, 16'h0);

    // Constrained random
    void'($urandom(32'd1357));
    for (int k = 0; k < 400; k++) begin
      logic [15:0] part;
      logic [15:0] ra;
      logic [15:0] rb;
      bit c;
      part = 16'($urandom);
      ra = 16'($urandom) & 16'($urandom) & part;
      rb = 16'($urandom) & 16'($urandom) & ~part;
      c  = ($urandom % 40) == 0;
      step("R2 R3 R4 R7 R8 random", c, ($urandom % 5) != 0, 1'($urandom),
           ($urandom % 3) == 0, int'($urandom % NCFG), int'($urandom % NCFG), ra, rb);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule